// File: doc/BRIEF.md
# Auto-Indexed Power Table Interface

This block holds an eight-entry table of one-byte amplifier power settings and gives an SPI host access to it through one header address. The host lowers chip select, sends a header byte and then one or more data bytes. An internal index picks the entry for each data byte. The index moves forward after every byte read or written, wraps from the last entry back to the first, and is forced to zero while chip select is high. A 3-bit select input picks one entry to drive the power-level output at all times. A sleep input wipes every entry except entry 0.

The serial inputs are sampled in the block's clock domain, which must run several times faster than the serial clock. The serial mode has an idle-low clock: the host drives MOSI before a rising edge and samples MISO on it, and the block shifts MISO after each falling edge. The index is shared by reads and writes. Within one chip-select window, a read issued after a single-byte write therefore sees the next entry. To read back the entry just written, the host must raise chip select first.

Top module: `pt_power_table`

## Requirements
- R1: After reset, entry 0 holds 0xC6 and entries 1 to 7 hold 0x00.
- R2: A header byte carries read (1) or write (0) in bit 7, burst (1) or single (0) in bit 6, and the address in bits 5:0. Only address 0x3E reaches the table. Any other address leaves every entry unchanged and keeps MISO low for the rest of that chip-select window.
- R3: In a burst write, the data bytes land in consecutive entries, starting from index 0 when the window opens.
- R4: The index wraps from 7 back to 0, so the ninth data byte of a burst goes to entry 0.
- R5: While chip select is high, the index is held at 0, so every new window starts at entry 0.
- R6: In single access, a new header is expected after one data byte, and the index is not reset. A single read that follows a single write in the same window returns the entry after the one written.
- R7: Read data leaves on MISO most significant bit first. The first bit is valid before the first rising serial-clock edge of the data byte, and MISO is 0 whenever the block is not sending table data.
- R8: power_o equals the entry selected by pa_sel_i, one clock after the select or the entry changes.
- R9: While sleep_i is high, entries 1 to 7 are cleared to 0x00 and entry 0 keeps its value.
- R10: The index advances once per data byte, whether the byte is read or written, and the same index is used for both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| pa_sel_i | input | 3 | Picks the entry driven on power_o |
| sleep_i | input | 1 | Clears entries 1 to 7 while high |
| power_o | output | 8 | Currently selected power setting |

## Verification
Burst writes followed by burst reads in a fresh window show that bytes land in order from index 0. A nine-byte burst write followed by a ten-byte read separates correct wrapping from saturation or overrun. Mixed single-access headers in one window show that the index is shared between reads and writes and is reset only by chip select. A header with a neighbouring address, a sleep pulse and a sweep of the select input each show that nothing changes except the entries the requirements name.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned N_ENTRY       = 8;
  localparam int unsigned ADDR_W        = 6;
  localparam int unsigned HDR_RD_BIT    = 7;
  localparam int unsigned HDR_BURST_BIT = 6;
  localparam logic [ADDR_W-1:0] TBL_ADDR = 6'h3E;
  localparam logic [BYTE_W-1:0] ENTRY0_RST = 8'hC6;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } pt_state_e;
endpackage

// File: rtl/pt_spi_rx.sv
module pt_spi_rx #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              shift_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic             sclk_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [BYTE_W-2:0] sh_q;
  logic             rise, fall;

  assign rise = sclk_i & ~sclk_q & ~csn_i;
  assign fall = ~sclk_i & sclk_q & ~csn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      sh_q      <= '0;
    end else if (csn_i) begin
      bit_cnt_q <= '0;
      sh_q      <= '0;
    end else if (rise) begin
      sh_q <= {sh_q[BYTE_W-3:0], mosi_i};
      if (bit_cnt_q == CNT_W'(BYTE_W-1)) bit_cnt_q <= '0;
      else                               bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  // no shift on the fall that closes a byte: the next byte's MSB is already up
  assign shift_o    = fall && (bit_cnt_q != '0);
  assign byte_vld_o = rise && (bit_cnt_q == CNT_W'(BYTE_W-1));
  assign byte_o     = {sh_q, mosi_i};
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
#(
  parameter int unsigned BYTE_W  = pt_pkg::BYTE_W,
  parameter int unsigned N_ENTRY = pt_pkg::N_ENTRY,
  parameter logic [pt_pkg::ADDR_W-1:0] ADDR = pt_pkg::TBL_ADDR,
  localparam int unsigned IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              shift_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              miso_o
);
  pt_state_e         state_q;
  logic              rd_q, burst_q;
  logic [IDX_W-1:0]  idx_q, idx_inc;
  logic [BYTE_W-1:0] tx_q;
  logic              hdr_hit;

  assign idx_inc = (idx_q == IDX_W'(N_ENTRY-1)) ? '0 : idx_q + 1'b1;
  assign hdr_hit = (byte_i[ADDR_W-1:0] == ADDR);

  // header phase fetches the current entry, data phase prefetches the next
  assign rd_idx_o = (state_q == ST_DATA) ? idx_inc : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      idx_q   <= '0;
      tx_q    <= '0;
    end else if (csn_i) begin
      state_q <= ST_HDR;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      idx_q   <= '0;
      tx_q    <= '0;
    end else begin
      unique case (state_q)
        ST_HDR: if (byte_vld_i) begin
          if (hdr_hit) begin
            state_q <= ST_DATA;
            rd_q    <= byte_i[HDR_RD_BIT];
            burst_q <= byte_i[HDR_BURST_BIT];
            tx_q    <= byte_i[HDR_RD_BIT] ? rd_data_i : '0;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        ST_DATA: begin
          if (byte_vld_i) begin
            idx_q <= idx_inc;
            if (burst_q) begin
              tx_q <= rd_q ? rd_data_i : '0;
            end else begin
              state_q <= ST_HDR;
              tx_q    <= '0;
            end
          end else if (shift_i) begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
        ST_SKIP: ;
        default: state_q <= ST_HDR;
      endcase
    end
  end

  assign wr_en_o   = (state_q == ST_DATA) && byte_vld_i && !rd_q && !csn_i;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = byte_i;
  assign idx_o     = idx_q;
  assign miso_o    = !csn_i && (state_q == ST_DATA) && rd_q && tx_q[BYTE_W-1];
endmodule

// File: rtl/pt_table.sv
module pt_table #(
  parameter int unsigned BYTE_W  = pt_pkg::BYTE_W,
  parameter int unsigned N_ENTRY = pt_pkg::N_ENTRY,
  parameter logic [pt_pkg::BYTE_W-1:0] ENTRY0_RST = pt_pkg::ENTRY0_RST,
  localparam int unsigned IDX_W  = $clog2(N_ENTRY)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sleep_i,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [BYTE_W-1:0]              wr_data_i,
  input  logic [IDX_W-1:0]               rd_idx_i,
  output logic [BYTE_W-1:0]              rd_data_o,
  input  logic [IDX_W-1:0]               sel_i,
  output logic [BYTE_W-1:0]              power_o,
  output logic [N_ENTRY-1:0][BYTE_W-1:0] tbl_o
);
  logic [N_ENTRY-1:0][BYTE_W-1:0] mem_q;
  logic [BYTE_W-1:0]              power_q;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_entry
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    if (g == 0) begin : g_keep
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  mem_q[g] <= ENTRY0_RST;
        else if (hit) mem_q[g] <= wr_data_i;
      end
    end else begin : g_volatile
      // sleep wins over a concurrent write
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      mem_q[g] <= '0;
        else if (sleep_i) mem_q[g] <= '0;
        else if (hit)     mem_q[g] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) power_q <= '0;
    else         power_q <= mem_q[sel_i];
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign power_o   = power_q;
  assign tbl_o     = mem_q;
endmodule

// File: rtl/pt_power_table.sv
module pt_power_table #(
  parameter int unsigned BYTE_W  = pt_pkg::BYTE_W,
  parameter int unsigned N_ENTRY = pt_pkg::N_ENTRY,
  parameter logic [pt_pkg::ADDR_W-1:0] ADDR       = pt_pkg::TBL_ADDR,
  parameter logic [pt_pkg::BYTE_W-1:0] ENTRY0_RST = pt_pkg::ENTRY0_RST,
  localparam int unsigned IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [IDX_W-1:0]  pa_sel_i,
  input  logic              sleep_i,
  output logic [BYTE_W-1:0] power_o
);
  logic                           shift, byte_vld, wr_en;
  logic [BYTE_W-1:0]              rx_byte, rd_data, wr_data;
  logic [IDX_W-1:0]               rd_idx, wr_idx, idx;
  logic [N_ENTRY-1:0][BYTE_W-1:0] tbl;

  pt_spi_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i, .rst_ni, .csn_i, .sclk_i, .mosi_i,
    .shift_o(shift), .byte_vld_o(byte_vld), .byte_o(rx_byte)
  );

  pt_ctrl #(.BYTE_W(BYTE_W), .N_ENTRY(N_ENTRY), .ADDR(ADDR)) u_ctrl (
    .clk_i, .rst_ni, .csn_i,
    .shift_i(shift), .byte_vld_i(byte_vld), .byte_i(rx_byte),
    .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .idx_o(idx), .miso_o
  );

  pt_table #(.BYTE_W(BYTE_W), .N_ENTRY(N_ENTRY), .ENTRY0_RST(ENTRY0_RST)) u_tbl (
    .clk_i, .rst_ni, .sleep_i,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .sel_i(pa_sel_i), .power_o, .tbl_o(tbl)
  );
endmodule

// File: rtl/pt_power_table_chk.sv
module pt_power_table_chk #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_ENTRY = 8,
  localparam int unsigned IDX_W  = $clog2(N_ENTRY)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           csn_i,
  input logic                           sleep_i,
  input logic                           miso_o,
  input logic [IDX_W-1:0]               pa_sel_i,
  input logic [BYTE_W-1:0]              power_o,
  input logic [IDX_W-1:0]               idx,
  input logic [N_ENTRY-1:0][BYTE_W-1:0] tbl
);
  AST_IDX_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |=> (idx == '0)); // R5

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(idx) |-> (idx == '0 || idx == $past(idx) + 1'b1)); // R10

  AST_MISO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |-> !miso_o); // R7

  AST_SLEEP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (tbl[N_ENTRY-1:1] == '0)); // R9

  AST_ENTRY0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && csn_i) |=> $stable(tbl[0])); // R9

  AST_POWER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(pa_sel_i) && $stable(tbl)) ##1 ($stable(pa_sel_i) && $stable(tbl))
      |=> $stable(power_o)); // R8
endmodule

bind pt_power_table pt_power_table_chk #(.BYTE_W(BYTE_W), .N_ENTRY(N_ENTRY)) u_chk (
  .clk_i, .rst_ni, .csn_i, .sleep_i, .miso_o, .pa_sel_i, .power_o,
  .idx(idx), .tbl(tbl)
);

// File: tb/tb_pt_power_table.sv
module tb_pt_power_table;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       csn = 1'b1, sclk = 1'b0, mosi = 1'b0, sleep = 1'b0;
  logic [2:0] sel = '0;
  logic       miso;
  logic [7:0] power;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] model [8];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  pt_power_table dut (
    .clk_i(clk), .rst_ni(rst_ni), .csn_i(csn), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .pa_sel_i(sel), .sleep_i(sleep), .power_o(power)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); mosi = tx[i];
      wait_clk(3);    rx[i] = miso;
      sclk = 1'b1;    wait_clk(4);
      sclk = 1'b0;    wait_clk(4);
    end
  endtask

  task automatic cs_low();  @(negedge clk); csn = 1'b0; wait_clk(4); endtask
  task automatic cs_high(); wait_clk(4); csn = 1'b1; wait_clk(4); endtask

  task automatic expect_rd(input string tag, input logic [7:0] got, input logic [7:0] exp);
    exp_q.push_back(exp); tag_q.push_back(tag); act_q.push_back(got);
  endtask

  task automatic wr_burst(input int n, input logic [7:0] base);
    logic [7:0] rx;
    cs_low();
    spi_byte(8'h7E, rx);
    for (int i = 0; i < n; i++) begin
      spi_byte(base + 8'(i), rx);
      model[i % 8] = base + 8'(i);
    end
    cs_high();
  endtask

  task automatic rd_burst(input string tag, input int n);
    logic [7:0] rx;
    cs_low();
    spi_byte(8'hFE, rx);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, rx);
      expect_rd(tag, rx, model[i % 8]);
    end
    cs_high();
  endtask

  task automatic chk_power(input string tag, input logic [2:0] s);
    @(negedge clk); sel = s;
    wait_clk(3);
    chk(tag, power, model[s]);
  endtask

  initial begin
    logic [7:0] rx;
    model[0] = 8'hC6;
    for (int i = 1; i < 8; i++) model[i] = 8'h00;
    wait_clk(3); rst_ni = 1'b1; wait_clk(3);

    // R1 reset contents
    chk_power("R1 power sel0", 3'd0);
    chk_power("R1 power sel3", 3'd3);
    chk("R7 miso idle", {7'd0, miso}, 8'h00);
    rd_burst("R1/R7 reset readback", 8);

    // R3 burst write order, R5 new window from 0
    wr_burst(8, 8'hA0);
    rd_burst("R3/R5 burst order", 8);

    // R4 wrap on ninth byte
    wr_burst(9, 8'h11);
    rd_burst("R4 wrap", 10);

    // R6 single write then single read in one window
    cs_low();
    spi_byte(8'h3E, rx); spi_byte(8'h55, rx); model[0] = 8'h55;
    spi_byte(8'hBE, rx); spi_byte(8'h00, rx);
    expect_rd("R6 same-window read is next entry", rx, model[1]);
    cs_high();
    cs_low();
    spi_byte(8'hBE, rx); spi_byte(8'h00, rx);
    expect_rd("R5 read after csn high", rx, model[0]);
    cs_high();

    // R2 other address ignored, miso low
    cs_low();
    spi_byte(8'h7D, rx); spi_byte(8'hFF, rx); spi_byte(8'hFF, rx);
    chk("R2 miso low on other address", rx, 8'h00);
    cs_high();
    cs_low();
    spi_byte(8'hFD, rx); spi_byte(8'h00, rx);
    chk("R2 miso low on other address read", rx, 8'h00);
    cs_high();
    rd_burst("R2 table unchanged", 8);

    // R8 power select sweep
    for (int s = 0; s < 8; s++) chk_power("R8 power follows select", 3'(s));

    // R10 shared index across mixed single accesses
    cs_low();
    spi_byte(8'h3E, rx); spi_byte(8'hD1, rx); model[0] = 8'hD1;
    spi_byte(8'hBE, rx); spi_byte(8'h00, rx);
    expect_rd("R10 read uses shared index", rx, model[1]);
    spi_byte(8'h3E, rx); spi_byte(8'hD3, rx); model[2] = 8'hD3;
    cs_high();
    rd_burst("R10 shared index readback", 3);

    // R9 sleep keeps only entry 0
    @(negedge clk); sleep = 1'b1; wait_clk(2); sleep = 1'b0;
    for (int i = 1; i < 8; i++) model[i] = 8'h00;
    chk_power("R9 entry0 kept", 3'd0);
    chk_power("R9 entry2 cleared", 3'd2);
    rd_burst("R9 after sleep", 8);

    wait_clk(10);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule